// File: doc/BRIEF.md
# Push-Button Power On/Off Controller

This block decides when system power is applied. One active-low push button drives it. A press held long enough turns power on. While power is on, a press asks the processor to shut down through an active-low interrupt. Holding the button longer releases power regardless of the processor. The processor ends a shutdown by pulling an active-low kill input low. An undervoltage flag can start the same shutdown sequence as the button, and it keeps power off while the supply is low.

Every interval is counted in ticks of a one-millisecond strobe: the turn-on debounce, the power-on blanking window, the interrupt timing, the forced-off delay and the re-enable lockout. The three inputs pass through a synchronizer and a short glitch filter before the timing logic uses them. A parameter selects the polarity of the enable output. An input port adds extra milliseconds to the forced-off delay.

Top module: `pbpwr_ctrl`

## Requirements
- R1: After reset, power is off (`pwr_en` inactive) and `irq_n` is high.
- R2: From the off state, power turns on only after `btn_n` has been low for 32 consecutive ms. A release before then restarts the count.
- R3: While power is off and `supply_ok` is 0, the button is ignored and power stays off. Only the button can turn power on.
- R4: Power-on starts a 512 ms blanking window. During the window, the button, `supply_ok` and `kill_n` have no effect and `irq_n` stays high. If `kill_n` is 0 when the window ends, power is released.
- R5: Outside the blanking window, while power is on, `kill_n` = 0 releases power within one millisecond.
- R6: While power is on, `btn_n` = 0 or `supply_ok` = 0 held for 32 ms drives `irq_n` low. It stays low while that input stays low, and for at least 32 ms in total.
- R7: If the input that started the shutdown stays low for 64 ms plus `extra_ms` ms, power and the interrupt are released in the same cycle.
- R8: The first of the button and the undervoltage flag to go low owns the shutdown. The other input is ignored until the owner's sequence has finished.
- R9: After power is released, the button is ignored for 64 ms. The 32 ms turn-on count begins only after that lockout.
- R10: With `EN_ACTIVE_HIGH` = 1, `pwr_en` is high when power is on. With 0, `pwr_en` is low when power is on.
- R11: With `extra_ms` = 0, the forced-off delay is exactly the fixed 64 ms. Each unit of `extra_ms` adds one millisecond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | Single-cycle strobe, once per millisecond |
| btn_n | input | 1 | Push button, low when pressed |
| supply_ok | input | 1 | Undervoltage flag: 1 = supply fine, 0 = supply low |
| kill_n | input | 1 | Processor kill request, active low |
| extra_ms | input | XW | Extra forced-off delay in milliseconds |
| pwr_en | output | 1 | Power enable, polarity set by EN_ACTIVE_HIGH |
| irq_n | output | 1 | Shutdown interrupt to the processor, active low |

## Verification
The assertions check the following on every cycle:
- the interrupt is never active while power is off;
- power and the interrupt never fall apart;
- power turns on only from the off state with the supply good;
- power is released only into the lockout;
- kill in the on state releases power on the next cycle;
- the blanking window never ends early;
- the shutdown owner never changes mid-sequence.

The millisecond thresholds can only be shown by the bench's timed scenarios, which probe a few milliseconds on either side of each boundary. These are the 32 ms debounce and restart, the 512 ms abort, the interrupt minimum width, the 64 ms + `extra_ms` forced release, the lockout and the ownership hand-over. Random press lengths against random extra delays test the interrupt/forced-off boundaries further.

// File: rtl/pbpwr_pkg.sv
package pbpwr_pkg;

  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_BLANK = 3'd1,
    PS_ON    = 3'd2,
    PS_DOWN  = 3'd3,
    PS_HOLD  = 3'd4,
    PS_LOCK  = 3'd5
  } pwr_state_t;

  typedef enum logic {
    OWN_BTN = 1'b0,
    OWN_UV  = 1'b1
  } owner_t;

  // total hold time, in ms, after which power is forced off
  function automatic int unsigned force_ms(int unsigned base_ms, int unsigned extra);
    return base_ms + extra;
  endfunction

  // time, in ms since the owner went low, at which a released interrupt may end
  function automatic int unsigned hold_end_ms(int unsigned deb_ms, int unsigned min_ms);
    return deb_ms + min_ms;
  endfunction

endpackage

// File: rtl/pbpwr_cond.sv
module pbpwr_cond #(
  parameter int STAGES  = 2,
  parameter int FILT    = 3,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int FW = $clog2(FILT + 1);

  logic [STAGES-1:0] sync_q;
  logic [FW-1:0]     fcnt;
  logic              filt_q;
  logic              raw;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= RST_VAL;
        else if (g == 0) sync_q[g] <= din;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign raw = sync_q[STAGES-1];

  // output follows the synchronized input only after FILT agreeing cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= RST_VAL;
      fcnt   <= '0;
    end else if (raw == filt_q) begin
      fcnt <= '0;
    end else if (fcnt == FW'(FILT - 1)) begin
      filt_q <= raw;
      fcnt   <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign dout = filt_q;

  // the filter never flips against the synchronized level (input hygiene for R2)
  assert_filter_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(raw)));

endmodule

// File: rtl/pbpwr_msctr.sv
module pbpwr_msctr #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt
);
  logic at_max;
  assign at_max = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (tick && !at_max) cnt <= cnt + 1'b1;
  end

  // long forced-off delays must never wrap back to a short count (R7)
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !clr) |=> at_max);

endmodule

// File: rtl/pbpwr_fsm.sv
module pbpwr_fsm
  import pbpwr_pkg::*;
#(
  parameter int DEB_MS     = 32,
  parameter int BLANK_MS   = 512,
  parameter int PD_MIN_MS  = 64,
  parameter int INT_MIN_MS = 32,
  parameter int LOCK_MS    = 64,
  parameter int XW         = 16,
  parameter int CW         = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          btn_lo,
  input  logic          sup_lo,
  input  logic          kill_lo,
  input  logic [XW-1:0] extra_ms,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          en_on,
  output logic          int_on
);
  pwr_state_t st, nxt;
  owner_t     own, nxt_own;

  logic [CW-1:0] force_lim;
  logic deb_done, blank_done, force_done, hold_done, lock_done, int_due;
  logic owner_lo;

  assign force_lim  = CW'(force_ms(PD_MIN_MS, 32'(extra_ms)));
  assign deb_done   = cnt >= CW'(DEB_MS);
  assign blank_done = cnt >= CW'(BLANK_MS);
  assign force_done = cnt >= force_lim;
  assign hold_done  = cnt >= CW'(hold_end_ms(DEB_MS, INT_MIN_MS));
  assign lock_done  = cnt >= CW'(LOCK_MS);
  assign int_due    = cnt >= CW'(DEB_MS);
  assign owner_lo   = (own == OWN_BTN) ? btn_lo : sup_lo;

  assign en_on  = (st == PS_BLANK) || (st == PS_ON) || (st == PS_DOWN) || (st == PS_HOLD);
  assign int_on = ((st == PS_DOWN) && int_due) || (st == PS_HOLD);

  always_comb begin
    nxt     = st;
    nxt_own = own;
    cnt_clr = 1'b0;
    case (st)
      PS_OFF: begin
        if (!btn_lo || sup_lo) cnt_clr = 1'b1;
        else if (deb_done) nxt = PS_BLANK;
      end
      PS_BLANK: begin
        if (blank_done) nxt = kill_lo ? PS_LOCK : PS_ON;
      end
      PS_ON: begin
        if (kill_lo) nxt = PS_LOCK;
        else if (btn_lo) begin
          nxt     = PS_DOWN;
          nxt_own = OWN_BTN;
        end else if (sup_lo) begin
          nxt     = PS_DOWN;
          nxt_own = OWN_UV;
        end
      end
      PS_DOWN: begin
        if (kill_lo || force_done) nxt = PS_LOCK;
        else if (!owner_lo) nxt = int_due ? PS_HOLD : PS_ON;
      end
      PS_HOLD: begin
        if (kill_lo) nxt = PS_LOCK;
        else if (hold_done) nxt = PS_ON;
      end
      PS_LOCK: begin
        if (lock_done) nxt = PS_OFF;
      end
      default: nxt = PS_OFF;
    endcase
    // the interrupt hold keeps timing from the owner's first low edge
    if ((nxt != st) && !((st == PS_DOWN) && (nxt == PS_HOLD))) cnt_clr = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PS_OFF;
      own <= OWN_BTN;
    end else begin
      st  <= nxt;
      own <= nxt_own;
    end
  end

  assert_rise_from_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_on) |-> ($past(st) == PS_OFF));

  assert_no_on_low_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_on) |-> !$past(sup_lo));

  assert_blank_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st) == PS_BLANK) && (st != PS_BLANK)) |-> $past(blank_done));

  assert_kill_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PS_ON) && kill_lo) |=> !en_on);

  assert_int_needs_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_on |-> en_on);

  assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_on) |-> !int_on);

  assert_owner_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PS_DOWN) && ($past(st) == PS_DOWN)) |-> $stable(own));

  assert_lockout_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_on) |-> (st == PS_LOCK));

endmodule

// File: rtl/pbpwr_ctrl.sv
module pbpwr_ctrl #(
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_CYC       = 3,
  parameter int DEB_MS         = 32,
  parameter int BLANK_MS       = 512,
  parameter int PD_MIN_MS      = 64,
  parameter int INT_MIN_MS     = 32,
  parameter int LOCK_MS        = 64,
  parameter int XW             = 16,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic          btn_n,
  input  logic          supply_ok,
  input  logic          kill_n,
  input  logic [XW-1:0] extra_ms,
  output logic          pwr_en,
  output logic          irq_n
);
  localparam int CW     = XW + 2;
  localparam int NIN    = 3;
  // reset levels per input: button idle high, supply good, kill asserted
  localparam logic [NIN-1:0] RST_VALS = 3'b011;

  logic [NIN-1:0] raw_in, clean_in;
  logic [CW-1:0]  ms_cnt;
  logic           cnt_clr, en_on, int_on;
  logic           btn_lo, sup_lo, kill_lo;

  assign raw_in = {kill_n, supply_ok, btn_n};

  genvar i;
  generate
    for (i = 0; i < NIN; i++) begin : g_in
      pbpwr_cond #(
        .STAGES (SYNC_STAGES),
        .FILT   (FILT_CYC),
        .RST_VAL(RST_VALS[i])
      ) u_cond (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in[i]),
        .dout (clean_in[i])
      );
    end
  endgenerate

  assign btn_lo  = !clean_in[0];
  assign sup_lo  = !clean_in[1];
  assign kill_lo = !clean_in[2];

  pbpwr_msctr #(.CW(CW)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .tick (tick_ms),
    .cnt  (ms_cnt)
  );

  pbpwr_fsm #(
    .DEB_MS    (DEB_MS),
    .BLANK_MS  (BLANK_MS),
    .PD_MIN_MS (PD_MIN_MS),
    .INT_MIN_MS(INT_MIN_MS),
    .LOCK_MS   (LOCK_MS),
    .XW        (XW),
    .CW        (CW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_lo  (btn_lo),
    .sup_lo  (sup_lo),
    .kill_lo (kill_lo),
    .extra_ms(extra_ms),
    .cnt     (ms_cnt),
    .cnt_clr (cnt_clr),
    .en_on   (en_on),
    .int_on  (int_on)
  );

  generate
    if (EN_ACTIVE_HIGH) begin : g_pol_hi
      assign pwr_en = en_on;
    end else begin : g_pol_lo
      assign pwr_en = !en_on;
    end
  endgenerate

  assign irq_n = !int_on;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!int_on || !rst_n));

endmodule

// File: tb/pbpwr_ctrl_test.sv
module pbpwr_ctrl_test;
  localparam int TICK_CYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic btn_n = 1'b1;
  logic supply_ok = 1'b1;
  logic kill_n = 1'b0;
  logic [15:0] extra_ms = 16'd0;
  logic pwr_en, irq_n, pwr_en_lo, irq_n_lo;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pbpwr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
    .supply_ok(supply_ok), .kill_n(kill_n), .extra_ms(extra_ms),
    .pwr_en(pwr_en), .irq_n(irq_n)
  );

  pbpwr_ctrl #(.EN_ACTIVE_HIGH(1'b0)) uut_lo (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn_n(btn_n),
    .supply_ok(supply_ok), .kill_n(kill_n), .extra_ms(extra_ms),
    .pwr_en(pwr_en_lo), .irq_n(irq_n_lo)
  );

  initial begin
    forever begin
      repeat (TICK_CYC - 1) @(negedge clk);
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
    end
  end

  // expectation functions restated from the requirements
  function automatic bit exp_power(int held_ms, int extra);
    return held_ms < 64 + extra;
  endfunction

  function automatic bit exp_irq(int held_ms, int extra);
    return (held_ms >= 32) && (held_ms < 64 + extra);
  endfunction

  task automatic wait_ms(int n);
    repeat (n * TICK_CYC) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(string tag, bit exp_en, bit exp_int);
    check(pwr_en == exp_en, {tag, " power"}, int'(pwr_en), int'(exp_en));
    check(irq_n == !exp_int, {tag, " irq_n"}, int'(irq_n), int'(!exp_int));
    check(pwr_en_lo == !exp_en, "R10 low-polarity enable", int'(pwr_en_lo), int'(!exp_en));
  endtask

  task automatic power_up();
    btn_n = 1'b0;
    wait_ms(40);
    btn_n = 1'b1;
    wait_ms(520);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_ms(2);
    chk_out("R1 reset", 1'b0, 1'b0);

    // R2: short presses and a restarted debounce never turn power on
    btn_n = 1'b0; wait_ms(20); btn_n = 1'b1; wait_ms(20);
    chk_out("R2 short press", 1'b0, 1'b0);
    btn_n = 1'b0; wait_ms(20); btn_n = 1'b1; wait_ms(5);
    btn_n = 1'b0; wait_ms(20); btn_n = 1'b1; wait_ms(5);
    chk_out("R2 restart", 1'b0, 1'b0);

    // R3: low supply blocks turn-on
    supply_ok = 1'b0; wait_ms(5);
    btn_n = 1'b0; wait_ms(60);
    chk_out("R3 low supply press", 1'b0, 1'b0);
    btn_n = 1'b1; supply_ok = 1'b1; wait_ms(10);

    // R2/R4: turn on with kill held low; blanking then abort
    btn_n = 1'b0; wait_ms(28);
    chk_out("R2 before 32ms", 1'b0, 1'b0);
    wait_ms(8);
    chk_out("R2 after 32ms", 1'b1, 1'b0);
    wait_ms(4); btn_n = 1'b1;            // t=40
    wait_ms(60); btn_n = 1'b0;           // t=100, press inside blanking
    wait_ms(90);                         // t=190
    chk_out("R4 button ignored in blank", 1'b1, 1'b0);
    wait_ms(10); btn_n = 1'b1;           // t=200
    supply_ok = 1'b0; wait_ms(60);       // t=260
    chk_out("R4 supply ignored in blank", 1'b1, 1'b0);
    supply_ok = 1'b1;
    wait_ms(272);                        // t=532
    chk_out("R4 still on near end", 1'b1, 1'b0);
    wait_ms(20);                         // t=552
    chk_out("R4 abort with kill low", 1'b0, 1'b0);

    // R9: press during lockout; debounce only counts after it
    btn_n = 1'b0; wait_ms(80);
    chk_out("R9 lockout", 1'b0, 1'b0);
    btn_n = 1'b1;
    kill_n = 1'b1; wait_ms(70);

    // normal power-up with kill high
    power_up();
    chk_out("R4 kill high keeps power", 1'b1, 1'b0);

    // R6: interrupt after 32 ms, held while pressed
    btn_n = 1'b0; wait_ms(28);
    chk_out("R6 before 32ms", 1'b1, 1'b0);
    wait_ms(8);
    chk_out("R6 irq asserted", 1'b1, 1'b1);
    wait_ms(14); btn_n = 1'b1;           // t=50
    wait_ms(8);
    chk_out("R6 irq after release within min", 1'b1, 1'b1);
    wait_ms(12);
    chk_out("R6 irq ended", 1'b1, 1'b0);
    // R6 minimum width on a barely long press
    btn_n = 1'b0; wait_ms(36); btn_n = 1'b1;
    wait_ms(14);
    chk_out("R6 minimum width", 1'b1, 1'b1);
    wait_ms(20);
    chk_out("R6 minimum width end", 1'b1, 1'b0);

    // R8: button owns; undervoltage ignored until owner finished
    btn_n = 1'b0; wait_ms(10);
    supply_ok = 1'b0; wait_ms(40);       // t=50
    btn_n = 1'b1; wait_ms(25);           // t=75
    chk_out("R8 supply ignored while button owns", 1'b1, 1'b0);
    wait_ms(13);                         // t=88
    chk_out("R8 supply restarts count", 1'b1, 1'b0);
    wait_ms(12);                         // t=100
    chk_out("R8 supply becomes owner", 1'b1, 1'b1);
    wait_ms(10); supply_ok = 1'b1;       // t=110
    wait_ms(10);
    chk_out("R6 supply irq min width", 1'b1, 1'b1);
    wait_ms(15);
    chk_out("R8 supply sequence ended", 1'b1, 1'b0);
    wait_ms(10);

    // R7/R11: forced off with no extra delay
    btn_n = 1'b0; wait_ms(60);
    chk_out("R11 before 64ms", 1'b1, 1'b1);
    wait_ms(10);
    chk_out("R7 forced off", 1'b0, 1'b0);
    btn_n = 1'b1; wait_ms(70);

    // R11: extra delay of 40 ms via the undervoltage flag
    extra_ms = 16'd40;
    power_up();
    supply_ok = 1'b0; wait_ms(100);
    chk_out("R11 extra delay holds", 1'b1, 1'b1);
    wait_ms(8);
    chk_out("R11 forced off after extra", 1'b0, 1'b0);
    wait_ms(70);
    btn_n = 1'b0; wait_ms(60);
    chk_out("R3 lockout by low supply", 1'b0, 1'b0);
    btn_n = 1'b1; supply_ok = 1'b1; extra_ms = 16'd0; wait_ms(70);

    // R5: kill during normal operation
    power_up();
    kill_n = 1'b0; wait_ms(1);
    chk_out("R5 kill release", 1'b0, 1'b0);
    kill_n = 1'b1; wait_ms(70);

    // random presses in the on state
    power_up();
    for (int it = 0; it < 8; it++) begin
      int extra;
      int dur;
      bit want_en;
      extra = int'($urandom_range(0, 30));
      extra_ms = 16'(extra);
      do begin
        dur = int'($urandom_range(5, 120));
      end while (((dur >= 29) && (dur <= 35)) ||
                 ((dur >= 61 + extra) && (dur <= 67 + extra)));
      want_en = exp_power(dur, extra);
      btn_n = 1'b0; wait_ms(dur);
      chk_out($sformatf("R7 random hold %0d extra %0d", dur, extra),
              want_en, exp_irq(dur, extra));
      btn_n = 1'b1; wait_ms(80);
      chk_out("R6 random settle", want_en, 1'b0);
      if (!want_en) power_up();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule